// File: doc/BRIEF.md
# Receive-Queue Watermark Flow Controller

This block sits beside a 12 KB receive queue and a full-duplex Ethernet MAC and decides two things: when to ask the link partner to stop sending, and when to keep the local transmitter from starting a new frame. It watches the queue's free space, counted in 4-byte double words, against two watermarks held in small registers. The high watermark produces a single pause request each time free space drops to it. The lower overrun watermark produces a warning level that follows the free space directly.

In the other direction, a decoded PAUSE frame from the partner loads a 16-bit pause timer. The timer counts down on a slot tick that the MAC supplies once per 512 bit times. While it is non-zero, the transmitter is held between frames. A frame that is already being sent is never cut short. Pause generation and pause honouring each have their own enable. Both act only while the link runs in full duplex.

Top module: `rxq_flow_ctrl`

## Requirements
- R1: After a synchronous reset, pause_req and tx_hold are 0, the high watermark is 768 double words and the overrun watermark is 64 double words.
- R2: With tx_fc_en=1 and full_duplex=1, a free_dw value at or below the high watermark, sampled at a clock edge while the generator is armed, makes pause_req high for exactly the following cycle.
- R3: After one pause request the generator stays disarmed. It re-arms only at an edge where free_dw is strictly greater than the high watermark plus 32, so one crossing yields one request.
- R4: With tx_fc_en=0 or full_duplex=0, pause_req stays 0 whatever free_dw does.
- R5: overrun_warn is combinational and equals (free_dw <= overrun watermark). It rises and falls in the same cycle as free_dw.
- R6: With rx_fc_en=1 and full_duplex=1, a pause_rx_stb loads pause_quanta into the timer. If tx_busy is 0, tx_hold is high from the next edge on.
- R7: Each quanta_tick while the timer is non-zero decrements it by one. tx_hold falls at the edge that takes the timer to zero, so a quanta of Q releases the hold at the edge that samples the Q-th tick.
- R8: A new pause_rx_stb reloads the timer, and it wins over a tick sampled at the same edge. A quanta of 0 clears tx_hold at that edge.
- R9: With rx_fc_en=0 or full_duplex=0, pause_rx_stb is ignored, and dropping either signal clears the timer and tx_hold at the next edge.
- R10: tx_hold rises only at an edge where tx_busy is 0. While a frame is in progress a pending pause waits, and tx_hold rises at the first edge after tx_busy falls if the timer is still running.
- R11: A wm_hi_we (or wm_ovr_we) pulse writes wm_data into the high (or overrun) watermark. The new value is used from the next edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| free_dw | input | 12 | Free receive-queue space in double words |
| full_duplex | input | 1 | Link is in full duplex |
| tx_fc_en | input | 1 | Enable pause generation |
| rx_fc_en | input | 1 | Enable honouring of received pauses |
| wm_hi_we | input | 1 | Write strobe for the high watermark |
| wm_ovr_we | input | 1 | Write strobe for the overrun watermark |
| wm_data | input | 12 | Watermark write value in double words |
| pause_rx_stb | input | 1 | One-cycle strobe: a PAUSE frame was decoded |
| pause_quanta | input | 16 | Quanta carried by the decoded PAUSE |
| quanta_tick | input | 1 | One pulse per 512 bit times |
| tx_busy | input | 1 | Transmitter is in the middle of a frame |
| pause_req | output | 1 | One-cycle request to send a PAUSE frame |
| tx_hold | output | 1 | Do not start a new transmit frame |
| overrun_warn | output | 1 | Free space at or below the overrun watermark |

## Verification
pause_req, tx_hold and both watermark registers are due one edge after the inputs that cause them. overrun_warn is due in the same cycle as free_dw and the current overrun watermark. The bench drives inputs 2 ns after each rising edge. A behavioural model updates its state at the rising edge from those stable inputs. All outputs are compared with the model at the following falling edge, and the comb output is checked against the inputs that are then present. Directed sequences cover the pause-request crossing, re-arm at exactly plus 32 and plus 33, timer expiry, reload, zero quanta, a pause arriving while a frame is in progress, and half-duplex gating.

// File: rtl/rxfc_pkg.sv
package rxfc_pkg;
  localparam int RXQ_BYTES  = 12288;
  localparam int DW_BYTES   = 4;
  localparam int RXQ_DW     = RXQ_BYTES / DW_BYTES;
  localparam int LVL_W      = $clog2(RXQ_DW + 1);
  localparam int QNT_W      = 16;
  localparam int HI_WM_DEF  = 768;
  localparam int OVR_WM_DEF = 64;
  localparam int REARM_HYST = 32;
  localparam int NUM_WM     = 2;

  typedef enum int {WM_HIGH = 0, WM_OVR = 1} wm_slot_e;
endpackage

// File: rtl/fc_wm_bank.sv
module fc_wm_bank #(
  parameter int LVL_W   = rxfc_pkg::LVL_W,
  parameter int HI_DEF  = rxfc_pkg::HI_WM_DEF,
  parameter int OVR_DEF = rxfc_pkg::OVR_WM_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hi_we,
  input  logic             ovr_we,
  input  logic [LVL_W-1:0] wr_data,
  output logic [LVL_W-1:0] hi_wm,
  output logic [LVL_W-1:0] ovr_wm
);
  import rxfc_pkg::*;

  logic [NUM_WM-1:0] we_vec;
  logic [LVL_W-1:0]  wm_q [NUM_WM];

  assign we_vec[WM_HIGH] = hi_we;
  assign we_vec[WM_OVR]  = ovr_we;

  for (genvar i = 0; i < NUM_WM; i++) begin : g_wm
    localparam logic [LVL_W-1:0] RST_VAL =
      (i == WM_HIGH) ? LVL_W'(HI_DEF) : LVL_W'(OVR_DEF);
    always_ff @(posedge clk) begin
      if (rst)            wm_q[i] <= RST_VAL;
      else if (we_vec[i]) wm_q[i] <= wr_data;
    end
  end

  assign hi_wm  = wm_q[WM_HIGH];
  assign ovr_wm = wm_q[WM_OVR];

  assert_hi_load_R11: assert property (@(posedge clk) disable iff (rst)
    hi_we |=> (hi_wm == $past(wr_data)));
  assert_ovr_load_R11: assert property (@(posedge clk) disable iff (rst)
    ovr_we |=> (ovr_wm == $past(wr_data)));
endmodule

// File: rtl/fc_pause_gen.sv
module fc_pause_gen #(
  parameter int LVL_W = rxfc_pkg::LVL_W,
  parameter int HYST  = rxfc_pkg::REARM_HYST
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             gen_en,
  input  logic [LVL_W-1:0] free_dw,
  input  logic [LVL_W-1:0] hi_wm,
  output logic             pause_req
);
  logic         armed_q;
  logic         fire;
  logic         below_hi;
  logic         above_rearm;
  logic [LVL_W:0] rearm_lvl;

  assign rearm_lvl   = {1'b0, hi_wm} + (LVL_W+1)'(HYST);
  assign below_hi    = (free_dw <= hi_wm);
  assign above_rearm = ({1'b0, free_dw} > rearm_lvl);
  assign fire        = gen_en && armed_q && below_hi;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q   <= 1'b1;
      pause_req <= 1'b0;
    end else begin
      pause_req <= fire;
      if (fire)             armed_q <= 1'b0;
      else if (above_rearm) armed_q <= 1'b1;
    end
  end

  assert_req_single_R3: assert property (@(posedge clk) disable iff (rst)
    pause_req |=> !pause_req);
  assert_req_gated_R4: assert property (@(posedge clk) disable iff (rst)
    pause_req |-> $past(gen_en));
  assert_req_level_R2: assert property (@(posedge clk) disable iff (rst)
    pause_req |-> $past(free_dw <= hi_wm));
endmodule

// File: rtl/fc_pause_timer.sv
module fc_pause_timer #(
  parameter int QNT_W = rxfc_pkg::QNT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             honor_en,
  input  logic             pause_stb,
  input  logic [QNT_W-1:0] quanta,
  input  logic             tick,
  input  logic             tx_busy,
  output logic             tx_hold
);
  logic [QNT_W-1:0] cnt_q;
  logic [QNT_W-1:0] cnt_nx;
  logic             hold_nx;

  always_comb begin
    cnt_nx = cnt_q;
    if (!honor_en)                     cnt_nx = '0;
    else if (pause_stb)                cnt_nx = quanta;
    else if (tick && (cnt_q != '0))    cnt_nx = cnt_q - 1'b1;
    hold_nx = (cnt_nx != '0) && (tx_hold || !tx_busy);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      tx_hold <= 1'b0;
    end else begin
      cnt_q   <= cnt_nx;
      tx_hold <= hold_nx;
    end
  end

  assert_hold_rise_idle_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_hold) |-> !$past(tx_busy));
  assert_hold_gated_R9: assert property (@(posedge clk) disable iff (rst)
    tx_hold |-> $past(honor_en));
  assert_zero_quanta_R8: assert property (@(posedge clk) disable iff (rst)
    (honor_en && pause_stb && (quanta == '0)) |=> !tx_hold);
  assert_hold_keeps_R7: assert property (@(posedge clk) disable iff (rst)
    (tx_hold && honor_en && !pause_stb && !tick) |=> tx_hold);
endmodule

// File: rtl/rxq_flow_ctrl.sv
module rxq_flow_ctrl #(
  parameter int LVL_W   = rxfc_pkg::LVL_W,
  parameter int QNT_W   = rxfc_pkg::QNT_W,
  parameter int HI_DEF  = rxfc_pkg::HI_WM_DEF,
  parameter int OVR_DEF = rxfc_pkg::OVR_WM_DEF,
  parameter int HYST    = rxfc_pkg::REARM_HYST
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LVL_W-1:0] free_dw,
  input  logic             full_duplex,
  input  logic             tx_fc_en,
  input  logic             rx_fc_en,
  input  logic             wm_hi_we,
  input  logic             wm_ovr_we,
  input  logic [LVL_W-1:0] wm_data,
  input  logic             pause_rx_stb,
  input  logic [QNT_W-1:0] pause_quanta,
  input  logic             quanta_tick,
  input  logic             tx_busy,
  output logic             pause_req,
  output logic             tx_hold,
  output logic             overrun_warn
);
  logic [LVL_W-1:0] hi_wm;
  logic [LVL_W-1:0] ovr_wm;
  logic             gen_en;
  logic             honor_en;

  assign gen_en   = tx_fc_en && full_duplex;
  assign honor_en = rx_fc_en && full_duplex;

  fc_wm_bank #(.LVL_W(LVL_W), .HI_DEF(HI_DEF), .OVR_DEF(OVR_DEF)) u_wm (
    .clk(clk), .rst(rst), .hi_we(wm_hi_we), .ovr_we(wm_ovr_we),
    .wr_data(wm_data), .hi_wm(hi_wm), .ovr_wm(ovr_wm)
  );

  fc_pause_gen #(.LVL_W(LVL_W), .HYST(HYST)) u_gen (
    .clk(clk), .rst(rst), .gen_en(gen_en), .free_dw(free_dw),
    .hi_wm(hi_wm), .pause_req(pause_req)
  );

  fc_pause_timer #(.QNT_W(QNT_W)) u_tmr (
    .clk(clk), .rst(rst), .honor_en(honor_en), .pause_stb(pause_rx_stb),
    .quanta(pause_quanta), .tick(quanta_tick), .tx_busy(tx_busy),
    .tx_hold(tx_hold)
  );

  assign overrun_warn = (free_dw <= ovr_wm);

  assert_gen_off_half_R4: assert property (@(posedge clk) disable iff (rst)
    !full_duplex |=> !pause_req);
  assert_hold_off_half_R9: assert property (@(posedge clk) disable iff (rst)
    !full_duplex |=> !tx_hold);
endmodule

// File: tb/rxq_flow_ctrl_bench.sv
`timescale 1ns/1ps
module rxq_flow_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] free_dw = 12'd3072;
  logic        full_duplex = 1'b1;
  logic        tx_fc_en = 1'b0;
  logic        rx_fc_en = 1'b0;
  logic        wm_hi_we = 1'b0;
  logic        wm_ovr_we = 1'b0;
  logic [11:0] wm_data = '0;
  logic        pause_rx_stb = 1'b0;
  logic [15:0] pause_quanta = '0;
  logic        quanta_tick = 1'b0;
  logic        tx_busy = 1'b0;
  logic        pause_req, tx_hold, overrun_warn;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  string tag = "R1";

  // reference model state
  int  m_hi, m_ovr, m_cnt;
  bit  m_armed, m_req, m_hold;

  always #4 clk = ~clk;

  rxq_flow_ctrl u_rxq_flow_ctrl (
    .clk(clk), .rst(rst), .free_dw(free_dw), .full_duplex(full_duplex),
    .tx_fc_en(tx_fc_en), .rx_fc_en(rx_fc_en), .wm_hi_we(wm_hi_we),
    .wm_ovr_we(wm_ovr_we), .wm_data(wm_data), .pause_rx_stb(pause_rx_stb),
    .pause_quanta(pause_quanta), .quanta_tick(quanta_tick),
    .tx_busy(tx_busy), .pause_req(pause_req), .tx_hold(tx_hold),
    .overrun_warn(overrun_warn)
  );

  task automatic chk(input string req, input string what,
                     input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    bit fire;
    cycles++;
    if (rst) begin
      m_hi = 768; m_ovr = 64; m_armed = 1; m_req = 0; m_cnt = 0; m_hold = 0;
    end else begin
      fire = tx_fc_en && full_duplex && m_armed && (int'(free_dw) <= m_hi);
      if (fire) m_armed = 0;
      else if (int'(free_dw) > m_hi + 32) m_armed = 1;
      m_req = fire;
      if (!(rx_fc_en && full_duplex)) m_cnt = 0;
      else if (pause_rx_stb) m_cnt = int'(pause_quanta);
      else if (quanta_tick && m_cnt > 0) m_cnt = m_cnt - 1;
      m_hold = (m_cnt != 0) && (m_hold || !tx_busy);
      if (wm_hi_we)  m_hi  = int'(wm_data);
      if (wm_ovr_we) m_ovr = int'(wm_data);
    end
    if (cycles > 100000) begin
      bad++;
      $display("FAIL watchdog expired actual=%0d expected=0", cycles);
      finish_run();
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      chk(tag, "pause_req", int'(pause_req), int'(m_req));
      chk(tag, "tx_hold", int'(tx_hold), int'(m_hold));
      chk(tag, "overrun_warn", int'(overrun_warn), int'(int'(free_dw) <= m_ovr));
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #2;
    end
  endtask

  task automatic set_free(input int v);
    free_dw = 12'(v);
    step(1);
  endtask

  task automatic pause_in(input int q);
    pause_quanta = 16'(q);
    pause_rx_stb = 1'b1;
    step(1);
    pause_rx_stb = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      quanta_tick = 1'b1;
      step(1);
      quanta_tick = 1'b0;
      step(1);
    end
  endtask

  initial begin
    // R1: reset state seen at the ports
    step(3);
    @(negedge clk);
    chk("R1", "pause_req in reset", int'(pause_req), 0);
    chk("R1", "tx_hold in reset", int'(tx_hold), 0);
    @(posedge clk); #2;
    rst = 1'b0;
    step(2);

    // R1 R5: default overrun watermark 64
    tag = "R5";
    set_free(65); set_free(64); set_free(63); set_free(65);
    chk("R5", "overrun at 65", int'(overrun_warn), 0);
    free_dw = 12'd64; #1;
    chk("R1", "overrun at default 64", int'(overrun_warn), 1);
    step(1);

    // R2: default high watermark crossing
    tag = "R2";
    tx_fc_en = 1'b1;
    set_free(900); set_free(769);
    set_free(768);
    @(negedge clk);
    chk("R2", "pause at 768", int'(pause_req), 1);
    @(posedge clk); #2;
    // R3: one request per crossing, re-arm only above hi+32
    tag = "R3";
    set_free(700); set_free(500); set_free(800); set_free(760);
    set_free(801); set_free(768); set_free(750); step(2);

    // R4: gating
    tag = "R4";
    set_free(1500); full_duplex = 1'b0; set_free(100); set_free(1500);
    full_duplex = 1'b1; tx_fc_en = 1'b0; set_free(100); set_free(1500);
    tx_fc_en = 1'b1; step(2);

    // R11: watermark writes
    tag = "R11";
    wm_data = 12'd1000; wm_hi_we = 1'b1; step(1); wm_hi_we = 1'b0;
    wm_data = 12'd200; wm_ovr_we = 1'b1; step(1); wm_ovr_we = 1'b0;
    set_free(1033); set_free(1000); set_free(1032); set_free(1033); set_free(990);
    set_free(201); set_free(200); set_free(3000);

    // R6 R7: load and expire
    tag = "R6";
    rx_fc_en = 1'b1; step(1);
    pause_in(3);
    @(negedge clk);
    chk("R6", "hold after pause", int'(tx_hold), 1);
    @(posedge clk); #2;
    tag = "R7";
    ticks(2); step(3); ticks(2); step(2);
    // R8: reload, reload vs tick, zero quanta
    tag = "R8";
    pause_in(2); ticks(1);
    pause_in(4); quanta_tick = 1'b1; pause_in(2); quanta_tick = 1'b0;
    step(2); ticks(1); pause_in(0); step(2);
    pause_in(5); ticks(1); pause_in(0);
    @(negedge clk);
    chk("R8", "zero quanta release", int'(tx_hold), 0);
    @(posedge clk); #2;

    // R10: pause while a frame is in progress
    tag = "R10";
    tx_busy = 1'b1; pause_in(4); step(3); ticks(1);
    tx_busy = 1'b0; step(2); tx_busy = 1'b1; step(2); ticks(3); tx_busy = 1'b0; step(2);
    tx_busy = 1'b1; pause_in(1); ticks(1); tx_busy = 1'b0; step(2);

    // R9: gating of pause honouring
    tag = "R9";
    rx_fc_en = 1'b0; pause_in(6); step(2);
    rx_fc_en = 1'b1; pause_in(6); step(1);
    full_duplex = 1'b0; step(2); pause_in(6); step(1);
    full_duplex = 1'b1; pause_in(6); rx_fc_en = 1'b0; step(1);
    @(negedge clk);
    chk("R9", "hold cleared by disable", int'(tx_hold), 0);
    @(posedge clk); #2;
    step(3);
    finish_run();
  end
endmodule